// File: doc/BRIEF.md
# UDP Payload Extractor with Error-Tolerant Mode

This block sits behind an Ethernet MAC receive path. It takes frames one byte per beat, with start and end markers and a flag from the MAC that the frame check sequence failed. It checks the link, network and transport headers as they stream past. It passes on only the UDP payload of frames it accepts, along with a logical channel number and an error tag. A frame is accepted when it is IPv4/UDP without options, is addressed either to the local station or to an enabled multicast group, and carries a destination port found in a small match table.

Payload bytes go into a circular buffer under a tentative write pointer. The keep-or-discard choice is made on the last beat of the frame, so a rejected frame never shows on the output. In strict mode, damaged frames are dropped: a bad FCS, a bad IPv4 header checksum, a fragment, or a frame that ends early. In tolerant mode the same frames are still forwarded, with the error tag set on their final beat. Downstream sample processing then sees scattered bad samples instead of a hole in the stream.

Top module: `udp_rx_parser`

## Requirements
- R1: While reset is applied and directly after it, `out_valid` is low.
- R2: Only bytes at frame offsets 42 up to 42+L-1 are forwarded, where L is the UDP length field (offsets 38-39, big-endian) minus 8. Header bytes, Ethernet padding and the 4 trailing FCS bytes never appear on the output. `out_sop` marks the first payload byte and `out_eop` marks the last.
- R3: A frame is dropped unless all of these hold: EtherType (offsets 12-13) is 0x0800, offset 14 is 0x45, and the protocol byte (offset 23) is 17.
- R4: A unicast frame is accepted only if its destination MAC (offsets 0-5) equals `cfg_mac` and its destination IP (offsets 30-33) equals `cfg_ip`.
- R5: A multicast frame is accepted when its destination MAC is 01:00:5E followed by the low 23 bits of the destination IP, and that IP equals an entry of `cfg_grp_ip` whose `cfg_grp_en` bit is set. A group with its enable bit clear is dropped.
- R6: The UDP destination port (offsets 36-37) selects the channel. The channel is the lowest table index whose entry equals the port. A table entry of 0 never matches. A port with no match is dropped.
- R7: With `cfg_tolerant`=0, a frame is discarded with no output if any of these hold: `in_fcs_err` is high on its end beat, the IPv4 header checksum is wrong, the more-fragments bit (0x20 of offset 20) is set or the fragment offset is nonzero, or the frame has fewer than 42+L+4 bytes.
- R8: With `cfg_tolerant`=1, those same frames are forwarded with `out_err`=1 on their end beat. A short frame forwards the payload bytes it actually carried.
- R9: `out_err` is high only on an end beat. Undamaged frames end with `out_err`=0.
- R10: A forwarded packet leaves on consecutive cycles, and `out_chan` stays constant from its first beat to its last.
- R11: A UDP length of 8 or less, or one giving L above `MAX_PAY`, drops the frame in either mode.
- R12: A start beat that arrives before the previous frame's end beat abandons the previous frame without output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tolerant | input | 1 | 1 = forward damaged frames with a tag, 0 = discard them |
| cfg_mac | input | 48 | Local station MAC address |
| cfg_ip | input | 32 | Local IPv4 address |
| cfg_grp_ip | input | 32*NGRP | Multicast group addresses, group 0 in the low bits |
| cfg_grp_en | input | NGRP | Enable bit for each group |
| cfg_port | input | 16*NCH | Destination-port table, entry 0 in the low bits |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_fcs_err | input | 1 | MAC reports FCS failure (sampled on the end beat) |
| in_data | input | 8 | Frame byte |
| out_valid | output | 1 | Payload byte valid |
| out_sop | output | 1 | First payload byte |
| out_eop | output | 1 | Last payload byte |
| out_err | output | 1 | Damaged-frame tag, on the end beat only |
| out_chan | output | clog2(NCH) | Channel index from the port table |
| out_data | output | 8 | Payload byte |

## Verification
The hardest case to reach from the ports is a frame that ends early in tolerant mode after some of its payload is already in the buffer. Only part of the payload must come out, and the tentative pointer must be committed rather than rolled back. The bench cuts a frame ten bytes into its payload and expects exactly those ten bytes with the tag. In a separate case it cuts a frame with no end beat and starts a new frame at once, which checks that the abandoned bytes are rolled back before the good frame is committed.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;
   // byte offsets inside an untagged Ethernet/IPv4(no options)/UDP frame
   localparam int OFS_TYPE  = 12;
   localparam int OFS_VIHL  = 14;
   localparam int OFS_CSUM0 = 14;
   localparam int OFS_FRAG  = 20;
   localparam int OFS_PROTO = 23;
   localparam int OFS_DIP   = 30;
   localparam int OFS_CSUM1 = 34;
   localparam int OFS_DPORT = 36;
   localparam int OFS_ULEN  = 38;
   localparam int OFS_LAST  = 41;
   localparam int PAY_OFS   = 42;
   localparam int UDP_HDR   = 8;
   localparam int TRAILER   = 4;

   localparam logic [15:0] TYPE_IPV4 = 16'h0800;
   localparam logic [7:0]  VIHL_MIN  = 8'h45;
   localparam logic [7:0]  PROTO_UDP = 8'd17;
   localparam logic [23:0] MC_OUI    = 24'h01005E;
endpackage

// File: rtl/udp_rx_chan.sv
module udp_rx_chan #(
   parameter int NCH = 4,
   parameter int CW  = 2
) (
   input  logic [15:0]       dport,
   input  logic [16*NCH-1:0] table_flat,
   output logic              hit,
   output logic [CW-1:0]     idx
);
   // scan downward so the lowest matching index is the one kept
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (table_flat[16*i +: 16] == dport && table_flat[16*i +: 16] != 16'h0) begin
            hit = 1'b1;
            idx = CW'(i);
         end
      end
   end
endmodule

// File: rtl/udp_rx_hdr.sv
module udp_rx_hdr
   import udp_rx_pkg::*;
#(
   parameter int NGRP    = 2,
   parameter int NCH     = 4,
   parameter int CW      = 2,
   parameter int LW      = 11,
   parameter int MAX_PAY = 1472
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_tolerant,
   input  logic [47:0]        cfg_mac,
   input  logic [31:0]        cfg_ip,
   input  logic [32*NGRP-1:0] cfg_grp_ip,
   input  logic [NGRP-1:0]    cfg_grp_en,
   input  logic [16*NCH-1:0]  cfg_port,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic               in_fcs_err,
   input  logic [7:0]         in_data,
   input  logic               room_ok,
   output logic [LW-1:0]      need,
   output logic               wr_en,
   output logic               commit,
   output logic               commit_err,
   output logic [CW-1:0]      commit_chan,
   output logic               rollback
);
   localparam int IW = $clog2(MAX_PAY + 64) + 1;

   logic [IW-1:0] idx_q, cur;
   int            ci;
   logic [47:0]   dmac;
   logic [15:0]   etype, frag, dport, ulen, plen_full;
   logic [7:0]    vihl, proto;
   logic [31:0]   dip;
   logic [19:0]   acc;
   logic          go;
   logic [CW-1:0] chan_q;

   assign cur = in_sop ? '0 : idx_q;
   always_comb ci = 32'(cur);

   // checksum fold
   logic [16:0] fold1;
   logic [15:0] fold2;
   logic        csum_ok;
   assign fold1   = {1'b0, acc[15:0]} + {13'b0, acc[19:16]};
   assign fold2   = fold1[15:0] + {15'b0, fold1[16]};
   assign csum_ok = (fold2 == 16'hFFFF);

   // addressing
   logic [NGRP-1:0] grp_hit;
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_hit[g] = cfg_grp_en[g] && (dip == cfg_grp_ip[32*g +: 32]);
   end
   logic ucast_ok, mcast_ok, hdr_ok, plen_ok, port_hit, frag_bad, trunc, dmg;
   logic [CW-1:0] port_idx;
   assign ucast_ok = (dmac == cfg_mac) && (dip == cfg_ip);
   assign mcast_ok = (dmac[47:23] == {MC_OUI, 1'b0}) && (dmac[22:0] == dip[22:0]) && |grp_hit;
   assign hdr_ok   = (etype == TYPE_IPV4) && (vihl == VIHL_MIN) && (proto == PROTO_UDP)
                     && (ucast_ok || mcast_ok);
   assign plen_full = ulen - 16'(UDP_HDR);
   assign plen_ok  = (ulen > 16'(UDP_HDR)) && (32'(plen_full) <= MAX_PAY);
   assign need     = LW'(plen_full);
   assign frag_bad = frag[13] || (frag[12:0] != 13'h0);

   udp_rx_chan #(.NCH(NCH), .CW(CW)) u_chan (
      .dport(dport), .table_flat(cfg_port), .hit(port_hit), .idx(port_idx)
   );

   // decision and buffer control
   assign wr_en = in_valid && go && (ci >= PAY_OFS) && (ci < PAY_OFS + 32'(plen_full));
   assign trunc = (ci + 1) < (PAY_OFS + 32'(plen_full) + TRAILER);
   assign dmg   = in_fcs_err || trunc || !csum_ok || frag_bad;
   assign commit      = in_valid && in_eop && go && (!dmg || cfg_tolerant);
   assign commit_err  = dmg;
   assign commit_chan = chan_q;
   assign rollback    = in_valid && (in_sop || (in_eop && !commit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;  go <= 1'b0;  chan_q <= '0;
         dmac <= '0;   etype <= '0; frag <= '0;  dport <= '0;
         ulen <= '0;   vihl <= '0;  proto <= '0; dip <= '0; acc <= '0;
      end else if (in_valid) begin
         idx_q <= (&cur) ? cur : cur + IW'(1);
         if (ci < 6) dmac <= {dmac[39:0], in_data};
         if (ci == OFS_TYPE || ci == OFS_TYPE + 1) etype <= {etype[7:0], in_data};
         if (ci == OFS_VIHL) vihl <= in_data;
         if (ci == OFS_FRAG || ci == OFS_FRAG + 1) frag <= {frag[7:0], in_data};
         if (ci == OFS_PROTO) proto <= in_data;
         if (ci >= OFS_DIP && ci < OFS_DIP + 4) dip <= {dip[23:0], in_data};
         if (ci == OFS_DPORT || ci == OFS_DPORT + 1) dport <= {dport[7:0], in_data};
         if (ci == OFS_ULEN || ci == OFS_ULEN + 1) ulen <= {ulen[7:0], in_data};
         if (ci >= OFS_CSUM0 && ci < OFS_CSUM1) begin
            if (ci == OFS_CSUM0) acc <= {4'h0, in_data, 8'h00};
            else if (ci[0] == 1'b0) acc <= acc + {4'h0, in_data, 8'h00};
            else acc <= acc + {12'h0, in_data};
         end
         if (in_eop || in_sop) go <= 1'b0;
         else if (ci == OFS_LAST) begin
            go     <= hdr_ok && port_hit && plen_ok && room_ok;
            chan_q <= port_idx;
         end
      end
   end

   p_write_needs_port_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> port_hit);
   p_write_inside_frame_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !in_sop);
endmodule

// File: rtl/udp_rx_buf.sv
module udp_rx_buf #(
   parameter int DEPTH  = 2048,
   parameter int MDEPTH = 4,
   parameter int CW     = 2,
   parameter int LW     = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          commit,
   input  logic          commit_err,
   input  logic [CW-1:0] commit_chan,
   input  logic          rollback,
   input  logic [LW-1:0] need,
   output logic          room_ok,
   output logic          out_valid,
   output logic          out_sop,
   output logic          out_eop,
   output logic          out_err,
   output logic [CW-1:0] out_chan,
   output logic [7:0]    out_data
);
   localparam int AW  = $clog2(DEPTH);
   localparam int MAW = $clog2(MDEPTH);
   localparam logic [AW:0]  DEPTH_P = (AW+1)'(DEPTH);
   localparam logic [AW:0]  P1  = (AW+1)'(1);
   localparam logic [MAW:0] M1  = (MAW+1)'(1);

   logic [7:0]    mem [DEPTH];
   logic [AW:0]   wr_t, wr_c, rd;
   logic [LW-1:0] mlen  [MDEPTH];
   logic [CW-1:0] mchan [MDEPTH];
   logic          merr  [MDEPTH];
   logic [MAW:0]  mw, mr, mcnt;
   logic [AW:0]   occ, free, frame_len;
   logic [LW-1:0] rem;
   logic          busy, first, cur_err;
   logic [CW-1:0] cur_chan;

   assign occ       = wr_c - rd;
   assign free      = DEPTH_P - occ;
   assign mcnt      = mw - mr;
   assign room_ok   = (32'(free) >= 32'(need)) && (32'(mcnt) < MDEPTH);
   assign frame_len = wr_t - wr_c + {{AW{1'b0}}, wr_en};

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_t[AW-1:0]] <= wr_data;
      if (commit) begin
         mlen[mw[MAW-1:0]]  <= LW'(frame_len);
         mchan[mw[MAW-1:0]] <= commit_chan;
         merr[mw[MAW-1:0]]  <= commit_err;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_t <= '0; wr_c <= '0; rd <= '0; mw <= '0; mr <= '0;
         rem <= '0; busy <= 1'b0; first <= 1'b0; cur_err <= 1'b0; cur_chan <= '0;
         out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0; out_err <= 1'b0;
         out_chan <= '0; out_data <= '0;
      end else begin
         if (commit) begin
            wr_t <= wr_t + {{AW{1'b0}}, wr_en};
            wr_c <= wr_t + {{AW{1'b0}}, wr_en};
            mw   <= mw + M1;
         end else if (rollback) begin
            wr_t <= wr_c;
         end else if (wr_en) begin
            wr_t <= wr_t + P1;
         end
         out_valid <= 1'b0;
         if (busy) begin
            out_valid <= 1'b1;
            out_data  <= mem[rd[AW-1:0]];
            out_sop   <= first;
            out_eop   <= (rem == LW'(1));
            out_err   <= (rem == LW'(1)) && cur_err;
            out_chan  <= cur_chan;
            rd        <= rd + P1;
            rem       <= rem - LW'(1);
            first     <= 1'b0;
            if (rem == LW'(1)) busy <= 1'b0;
         end else if (mcnt != '0) begin
            rem      <= mlen[mr[MAW-1:0]];
            cur_chan <= mchan[mr[MAW-1:0]];
            cur_err  <= merr[mr[MAW-1:0]];
            mr       <= mr + M1;
            busy     <= 1'b1;
            first    <= 1'b1;
         end
      end
   end

   p_no_overflow_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_t - rd) <= DEPTH_P);
   p_contiguous_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |=> out_valid);
   p_chan_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |=> $stable(out_chan));
   p_err_on_end_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> out_eop);
endmodule

// File: rtl/udp_rx_parser.sv
module udp_rx_parser #(
   parameter int NGRP       = 2,
   parameter int NCH        = 4,
   parameter int MAX_PAY    = 1472,
   parameter int BUF_DEPTH  = 2048,
   parameter int META_DEPTH = 4,
   localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int LW = $clog2(MAX_PAY + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_tolerant,
   input  logic [47:0]        cfg_mac,
   input  logic [31:0]        cfg_ip,
   input  logic [32*NGRP-1:0] cfg_grp_ip,
   input  logic [NGRP-1:0]    cfg_grp_en,
   input  logic [16*NCH-1:0]  cfg_port,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic               in_fcs_err,
   input  logic [7:0]         in_data,
   output logic               out_valid,
   output logic               out_sop,
   output logic               out_eop,
   output logic               out_err,
   output logic [CW-1:0]      out_chan,
   output logic [7:0]         out_data
);
   initial begin
      if (BUF_DEPTH < MAX_PAY || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0)
         $error("BUF_DEPTH must be a power of two holding MAX_PAY");
      if (META_DEPTH < 2 || (META_DEPTH & (META_DEPTH - 1)) != 0)
         $error("META_DEPTH must be a power of two of at least 2");
      if (NGRP < 1 || NCH < 1) $error("NGRP and NCH must be positive");
   end

   logic          wr_en, commit, commit_err, rollback, room_ok;
   logic [CW-1:0] commit_chan;
   logic [LW-1:0] need;

   udp_rx_hdr #(.NGRP(NGRP), .NCH(NCH), .CW(CW), .LW(LW), .MAX_PAY(MAX_PAY)) u_hdr (
      .clk(clk), .rst_n(rst_n), .cfg_tolerant(cfg_tolerant), .cfg_mac(cfg_mac),
      .cfg_ip(cfg_ip), .cfg_grp_ip(cfg_grp_ip), .cfg_grp_en(cfg_grp_en),
      .cfg_port(cfg_port), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_fcs_err(in_fcs_err), .in_data(in_data), .room_ok(room_ok), .need(need),
      .wr_en(wr_en), .commit(commit), .commit_err(commit_err),
      .commit_chan(commit_chan), .rollback(rollback)
   );

   udp_rx_buf #(.DEPTH(BUF_DEPTH), .MDEPTH(META_DEPTH), .CW(CW), .LW(LW)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data), .commit(commit),
      .commit_err(commit_err), .commit_chan(commit_chan), .rollback(rollback),
      .need(need), .room_ok(room_ok), .out_valid(out_valid), .out_sop(out_sop),
      .out_eop(out_eop), .out_err(out_err), .out_chan(out_chan), .out_data(out_data)
   );

   // R7: with the mode held steady, strict mode never emits a tagged packet
   p_strict_untagged_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> cfg_tolerant);
endmodule

// File: tb/udp_rx_parser_tb.sv
module udp_rx_parser_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        cfg_tolerant;
   logic [47:0] cfg_mac;
   logic [31:0] cfg_ip;
   logic [63:0] cfg_grp_ip;
   logic [1:0]  cfg_grp_en;
   logic [63:0] cfg_port;
   logic        in_valid = 0, in_sop = 0, in_eop = 0, in_fcs_err = 0;
   logic [7:0]  in_data = 0;
   logic        out_valid, out_sop, out_eop, out_err;
   logic [1:0]  out_chan;
   logic [7:0]  out_data;

   udp_rx_parser u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_tolerant(cfg_tolerant), .cfg_mac(cfg_mac),
      .cfg_ip(cfg_ip), .cfg_grp_ip(cfg_grp_ip), .cfg_grp_en(cfg_grp_en),
      .cfg_port(cfg_port), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_fcs_err(in_fcs_err), .in_data(in_data), .out_valid(out_valid),
      .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err), .out_chan(out_chan),
      .out_data(out_data)
   );

   typedef struct { logic [7:0] d; logic sop, eop, err; logic [1:0] ch; string req; } exp_t;
   exp_t  sb[$];
   int    total = 0, bad = 0;
   string cur_req = "R1";

   localparam logic [47:0] MY_MAC = 48'h02_00_00_00_00_01;
   localparam logic [31:0] MY_IP  = 32'hC0A8000A;
   localparam logic [31:0] GRP_ON = 32'hEF010203;
   localparam logic [31:0] GRP_OFF = 32'hEF000005;

   // frame options
   logic [15:0] o_type, o_frag, o_ulen;
   logic [7:0]  o_vihl, o_proto;
   logic        o_badcs, o_fcs, o_noeop;
   int          o_cut;
   logic [7:0]  fb[$];

   task automatic opts_default();
      o_type = 16'h0800; o_vihl = 8'h45; o_proto = 8'd17; o_frag = 16'h0;
      o_badcs = 0; o_fcs = 0; o_noeop = 0; o_cut = 0; o_ulen = 16'h0;
   endtask

   task automatic build(input logic [47:0] dmac, input logic [31:0] dip,
                        input logic [15:0] dport, input int plen, input logic [7:0] seed);
      logic [15:0] ul, tl;
      logic [31:0] s;
      fb.delete();
      ul = (o_ulen != 0) ? o_ulen : 16'(plen + 8);
      tl = ul + 16'd20;
      for (int i = 0; i < 6; i++) fb.push_back(dmac[47-8*i -: 8]);
      for (int i = 0; i < 6; i++) fb.push_back(8'h10 + 8'(i));
      fb.push_back(o_type[15:8]); fb.push_back(o_type[7:0]);
      fb.push_back(o_vihl); fb.push_back(8'h00);
      fb.push_back(tl[15:8]); fb.push_back(tl[7:0]);
      fb.push_back(8'h12); fb.push_back(8'h34);
      fb.push_back(o_frag[15:8]); fb.push_back(o_frag[7:0]);
      fb.push_back(8'd64); fb.push_back(o_proto);
      fb.push_back(8'h00); fb.push_back(8'h00);
      fb.push_back(8'hC0); fb.push_back(8'hA8); fb.push_back(8'h00); fb.push_back(8'h63);
      for (int i = 0; i < 4; i++) fb.push_back(dip[31-8*i -: 8]);
      fb.push_back(8'h27); fb.push_back(8'h10);
      fb.push_back(dport[15:8]); fb.push_back(dport[7:0]);
      fb.push_back(ul[15:8]); fb.push_back(ul[7:0]);
      fb.push_back(8'h00); fb.push_back(8'h00);
      for (int i = 0; i < plen; i++) fb.push_back(seed + 8'(i));
      while (fb.size() < 60) fb.push_back(8'hA5);
      for (int i = 0; i < 4; i++) fb.push_back(8'hF0 + 8'(i));
      s = 0;
      for (int i = 14; i < 34; i += 2) s += {16'h0, fb[i], fb[i+1]};
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      s[15:0] = ~s[15:0];
      if (o_badcs) s[0] = ~s[0];
      fb[24] = s[15:8]; fb[25] = s[7:0];
      if (o_cut > 0) while (fb.size() > o_cut) void'(fb.pop_back());
   endtask

   task automatic drive();
      for (int i = 0; i < fb.size(); i++) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_sop     = (i == 0);
         in_eop     = (i == fb.size() - 1) && !o_noeop;
         in_fcs_err = in_eop && o_fcs;
         in_data    = fb[i];
      end
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0; in_fcs_err = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_pkt(input logic [1:0] ch, input int n, input logic [7:0] seed,
                             input logic err, input string req);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.d = seed + 8'(i); e.sop = (i == 0); e.eop = (i == n - 1);
         e.err = err && (i == n - 1); e.ch = ch; e.req = req;
         sb.push_back(e);
      end
   endtask

   task automatic send(input logic [47:0] dmac, input logic [31:0] dip, input logic [15:0] dport,
                       input int plen, input logic [7:0] seed);
      build(dmac, dip, dport, plen, seed);
      drive();
   endtask

   task automatic settle();
      int w;
      w = 0;
      while (sb.size() != 0 && w < 4000) begin @(negedge clk); w++; end
      repeat (20) @(negedge clk);
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL %s: %0d expected payload bytes missing (expected 0)", cur_req, sb.size());
         sb.delete();
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL %s: unexpected output byte %h (expected none)", cur_req, out_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (out_data !== e.d || out_sop !== e.sop || out_eop !== e.eop ||
                out_err !== e.err || out_chan !== e.ch) begin
               bad++;
               $display("FAIL %s: got d=%h sop=%b eop=%b err=%b ch=%0d expected d=%h sop=%b eop=%b err=%b ch=%0d",
                        e.req, out_data, out_sop, out_eop, out_err, out_chan,
                        e.d, e.sop, e.eop, e.err, e.ch);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cfg_tolerant = 0; cfg_mac = MY_MAC; cfg_ip = MY_IP;
      cfg_grp_ip = {GRP_ON, GRP_OFF}; cfg_grp_en = 2'b10;
      cfg_port = {16'd0, 16'd6000, 16'd5001, 16'd5000};
      opts_default();
      repeat (4) @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin bad++; $display("FAIL R1: out_valid=%b expected 0 in reset", out_valid); end
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin bad++; $display("FAIL R1: out_valid=%b expected 0 after reset", out_valid); end

      // R2 R4 R6: unicast, padded short frame then longer frames on other channels
      cur_req = "R2";
      expect_pkt(2'd0, 5, 8'h30, 0, "R2 padded payload"); send(MY_MAC, MY_IP, 16'd5000, 5, 8'h30); settle();
      expect_pkt(2'd2, 100, 8'h01, 0, "R6 channel 2"); send(MY_MAC, MY_IP, 16'd6000, 100, 8'h01); settle();
      // R10: back-to-back frames, different channels
      cur_req = "R10";
      expect_pkt(2'd1, 40, 8'h80, 0, "R10 first");  send(MY_MAC, MY_IP, 16'd5001, 40, 8'h80);
      expect_pkt(2'd0, 20, 8'hC0, 0, "R10 second"); send(MY_MAC, MY_IP, 16'd5000, 20, 8'hC0);
      settle();

      // R5 multicast
      cur_req = "R5";
      expect_pkt(2'd0, 16, 8'h44, 0, "R5 enabled group");
      send({24'h01005E, 24'h010203}, GRP_ON, 16'd5000, 16, 8'h44); settle();
      send({24'h01005E, 24'h000005}, GRP_OFF, 16'd5000, 16, 8'h44); settle();

      // R4 address mismatch
      cur_req = "R4";
      send(48'h02_00_00_00_00_02, MY_IP, 16'd5000, 10, 8'h11); settle();
      send(MY_MAC, 32'hC0A8000B, 16'd5000, 10, 8'h11); settle();

      // R3 header type checks
      cur_req = "R3";
      o_type = 16'h86DD; send(MY_MAC, MY_IP, 16'd5000, 10, 8'h22); settle(); opts_default();
      o_vihl = 8'h46;    send(MY_MAC, MY_IP, 16'd5000, 10, 8'h22); settle(); opts_default();
      o_proto = 8'd6;    send(MY_MAC, MY_IP, 16'd5000, 10, 8'h22); settle(); opts_default();

      // R6 port table: no match, zero entry, lowest-index priority
      cur_req = "R6";
      send(MY_MAC, MY_IP, 16'd7000, 10, 8'h33); settle();
      send(MY_MAC, MY_IP, 16'd0, 10, 8'h33); settle();
      cfg_port[63:48] = 16'd6000;
      expect_pkt(2'd2, 12, 8'h55, 0, "R6 lowest index wins");
      send(MY_MAC, MY_IP, 16'd6000, 12, 8'h55); settle();
      cfg_port[63:48] = 16'd0;

      // R7 strict discards
      cur_req = "R7";
      o_fcs = 1;        send(MY_MAC, MY_IP, 16'd5000, 20, 8'h66); settle(); opts_default();
      o_badcs = 1;      send(MY_MAC, MY_IP, 16'd5000, 20, 8'h66); settle(); opts_default();
      o_frag = 16'h2000; send(MY_MAC, MY_IP, 16'd5000, 20, 8'h66); settle(); opts_default();
      o_frag = 16'h0010; send(MY_MAC, MY_IP, 16'd5000, 20, 8'h66); settle(); opts_default();
      o_cut = 52;       send(MY_MAC, MY_IP, 16'd5000, 30, 8'h66); settle(); opts_default();

      // R8 tolerant forwarding with tag
      cfg_tolerant = 1;
      cur_req = "R8";
      o_fcs = 1;   expect_pkt(2'd0, 20, 8'h70, 1, "R8 fcs"); send(MY_MAC, MY_IP, 16'd5000, 20, 8'h70); settle(); opts_default();
      o_badcs = 1; expect_pkt(2'd1, 20, 8'h71, 1, "R8 csum"); send(MY_MAC, MY_IP, 16'd5001, 20, 8'h71); settle(); opts_default();
      o_frag = 16'h2000; expect_pkt(2'd0, 20, 8'h72, 1, "R8 frag"); send(MY_MAC, MY_IP, 16'd5000, 20, 8'h72); settle(); opts_default();
      o_cut = 52;  expect_pkt(2'd0, 10, 8'h73, 1, "R8 short frame"); send(MY_MAC, MY_IP, 16'd5000, 30, 8'h73); settle(); opts_default();
      // R9: good frame in tolerant mode ends untagged
      cur_req = "R9";
      expect_pkt(2'd2, 8, 8'h74, 0, "R9 clean"); send(MY_MAC, MY_IP, 16'd6000, 8, 8'h74); settle();

      // R11 length limits, even in tolerant mode
      cur_req = "R11";
      o_ulen = 16'd8;    send(MY_MAC, MY_IP, 16'd5000, 0, 8'h75); settle(); opts_default();
      o_ulen = 16'd1481; send(MY_MAC, MY_IP, 16'd5000, 20, 8'h75); settle(); opts_default();

      // R12 start beat without previous end beat
      cur_req = "R12";
      o_noeop = 1; o_cut = 55; send(MY_MAC, MY_IP, 16'd5000, 30, 8'h90); opts_default();
      expect_pkt(2'd1, 25, 8'hA0, 0, "R12 following frame");
      send(MY_MAC, MY_IP, 16'd5001, 25, 8'hA0); settle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule